// File: doc/BRIEF.md
# Per-Pixel Single-Slope Conversion Array

This block models an image array in which every pixel converts its own level at the same time as all the others. A single sequencer sweeps a binary ramp through every code from 0 to 255. Alongside the ramp it broadcasts the same step as a Gray-coded count.

Each pixel has a comparator and an 8-bit memory. The memory copies the broadcast Gray count on every step until the pixel's comparator switches. On that step it keeps the value and holds it for the rest of the frame. The stored code is therefore the first step at which the ramp reached the pixel's level.

Once the sweep ends, the frame waits for a read request. The array is then drained row by row, eight pixels per bus word. Each stored Gray code is turned back into binary on the way out. A new frame can be started only after the drain has finished.

The pixel levels enter as digital codes on one flat input bus. The array size is a parameter: the default is a small 4 by 16 array, and a full 352 by 288 array is also a legal setting.

Top module: `dps_adc_array`

## Requirements
- R1: After reset, `rd_valid_o` is low. A read request made before any conversion produces no valid word.
- R2: One conversion sweeps the shared count through 256 consecutive steps. The Gray-coded count changes in exactly one bit from each step to the next.
- R3: The value read out for a pixel equals its 8-bit input level in binary. This holds for every level from 0 to 255, including 0 and full scale (255). The level of pixel p = r*COLS + c is bits [8p+7:8p] of `level_i`.
- R4: Once a pixel's comparator has switched, its memory does not change until the next conversion starts. Changing `level_i` after a conversion has no effect on the data read out for that frame.
- R5: After an accepted read request, exactly ROWS*COLS/8 words come out on consecutive cycles with `rd_valid_o` high, in row-major order. `rd_row_o` and `rd_word_o` name each word's position. Word w of row r carries columns 8w..8w+7, with column 8w+j on bits [8j+7:8j].
- R6: A start strobe is ignored while a conversion is running, while a converted frame is waiting, and while a frame is being read out.
- R7: A read request is ignored unless a converted frame is waiting. This includes a request made during a conversion. A frame is read out only once, so a second request after the drain produces no words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| level_i | input | ROWS*COLS*8 | Per-pixel level codes, pixel p on bits [8p+7:8p] |
| start_i | input | 1 | Start-of-conversion strobe |
| read_i | input | 1 | Readout request |
| rd_data_o | output | LANES*8 | Readout word, eight binary pixel codes |
| rd_valid_o | output | 1 | High while a readout word is on the bus |
| rd_row_o | output | max(1,clog2(ROWS)) | Row of the current word |
| rd_word_o | output | max(1,clog2(COLS/LANES)) | Word position within the row |

## Verification
A pixel memory that freezes one step late or early, or that never freezes, shows up as an off-by-one or full-scale value in its own lane. This appears in the first readout after that conversion. A counter that leaves Gray order corrupts the binary value of any pixel whose level lies near the faulty step. A sequencer that restarts or accepts a read at the wrong time shows up within a few cycles: the readout comes out short, comes out empty, or carries data converted from levels changed after the frame. An indexing fault in the readout shifts whole groups of eight pixels, so every word carries the wrong data or the wrong row or word index.

// File: rtl/dps_pkg.sv
package dps_pkg;

    localparam int CODE_W = 8;

    typedef logic [CODE_W-1:0] code_t;

    localparam code_t CODE_MAX = '1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CONV,
        ST_HOLD,
        ST_READ
    } seq_state_e;

    // Broadcast step as seen by every pixel
    typedef struct packed {
        logic  clear;
        logic  conv;
        code_t ramp;
        code_t gray;
    } step_bus_t;

    function automatic code_t bin2gray(code_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic code_t gray2bin(code_t g);
        code_t b;
        b[CODE_W-1] = g[CODE_W-1];
        for (int i = CODE_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/dps_sequencer.sv
module dps_sequencer
    import dps_pkg::*;
#(
    parameter int NWORDS = 8,
    localparam int IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             read_i,
    output seq_state_e       state_o,
    output step_bus_t        step_o,
    output logic             rd_en_o,
    output logic [IDX_W-1:0] word_idx_o
);

    localparam logic [IDX_W-1:0] LAST_WORD = IDX_W'(NWORDS - 1);

    seq_state_e       state;
    code_t            step;
    logic [IDX_W-1:0] widx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            step  <= '0;
            widx  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        state <= ST_CONV;
                        step  <= '0;
                    end
                end
                ST_CONV: begin
                    if (step == CODE_MAX) begin
                        state <= ST_HOLD;
                    end else begin
                        step <= step + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (read_i) begin
                        state <= ST_READ;
                        widx  <= '0;
                    end
                end
                ST_READ: begin
                    if (widx == LAST_WORD) begin
                        state <= ST_IDLE;
                    end else begin
                        widx <= widx + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        step_o.clear = (state == ST_IDLE) && start_i;
        step_o.conv  = (state == ST_CONV);
        step_o.ramp  = step;
        step_o.gray  = bin2gray(step);
    end

    assign state_o    = state;
    assign rd_en_o    = (state == ST_READ);
    assign word_idx_o = widx;

endmodule

// File: rtl/dps_pixel.sv
module dps_pixel
    import dps_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  step_bus_t step_i,
    input  code_t     level_i,
    output code_t     mem_o,
    output logic      frozen_o
);

    code_t mem;
    logic  frozen;
    logic  cmp;

    // Behavioural comparator: switches once the ramp reaches the level
    assign cmp = (step_i.ramp >= level_i);

    always_ff @(posedge clk) begin
        if (rst || step_i.clear) begin
            mem    <= '0;
            frozen <= 1'b0;
        end else if (step_i.conv && !frozen) begin
            mem <= step_i.gray;
            if (cmp) begin
                frozen <= 1'b1;
            end
        end
    end

    assign mem_o    = mem;
    assign frozen_o = frozen;

endmodule

// File: rtl/dps_readout.sv
module dps_readout
    import dps_pkg::*;
#(
    parameter int ROWS  = 4,
    parameter int COLS  = 16,
    parameter int LANES = 8,
    localparam int NPIX   = ROWS * COLS,
    localparam int WPR    = COLS / LANES,
    localparam int NWORDS = ROWS * WPR,
    localparam int IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1,
    localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int WRD_W  = (WPR > 1) ? $clog2(WPR) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    rd_en_i,
    input  logic [IDX_W-1:0]        word_idx_i,
    input  code_t [NPIX-1:0]        pix_mem_i,
    output logic [LANES*CODE_W-1:0] data_o,
    output logic                    valid_o,
    output logic [ROW_W-1:0]        row_o,
    output logic [WRD_W-1:0]        word_o
);

    code_t [LANES-1:0] lane_bin;
    logic [ROW_W-1:0]  row_n;
    logic [WRD_W-1:0]  word_n;

    always_comb begin
        int base;
        base   = int'(word_idx_i) * LANES;
        row_n  = ROW_W'(int'(word_idx_i) / WPR);
        word_n = WRD_W'(int'(word_idx_i) % WPR);
        for (int j = 0; j < LANES; j++) begin
            lane_bin[j] = gray2bin(pix_mem_i[base + j]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            data_o  <= '0;
            row_o   <= '0;
            word_o  <= '0;
        end else begin
            valid_o <= rd_en_i;
            if (rd_en_i) begin
                data_o <= lane_bin;
                row_o  <= row_n;
                word_o <= word_n;
            end
        end
    end

endmodule

// File: rtl/dps_adc_array.sv
module dps_adc_array
    import dps_pkg::*;
#(
    parameter int ROWS  = 4,
    parameter int COLS  = 16,
    parameter int LANES = 8,
    localparam int NPIX   = ROWS * COLS,
    localparam int WPR    = COLS / LANES,
    localparam int NWORDS = ROWS * WPR,
    localparam int IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1,
    localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int WRD_W  = (WPR > 1) ? $clog2(WPR) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NPIX*CODE_W-1:0]  level_i,
    input  logic                    start_i,
    input  logic                    read_i,
    output logic [LANES*CODE_W-1:0] rd_data_o,
    output logic                    rd_valid_o,
    output logic [ROW_W-1:0]        rd_row_o,
    output logic [WRD_W-1:0]        rd_word_o
);

    seq_state_e       seq_state;
    step_bus_t        step_bus;
    logic             rd_en;
    logic [IDX_W-1:0] word_idx;
    code_t [NPIX-1:0] pix_mem;
    logic [NPIX-1:0]  pix_frozen;

    dps_sequencer #(.NWORDS(NWORDS)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .read_i     (read_i),
        .state_o    (seq_state),
        .step_o     (step_bus),
        .rd_en_o    (rd_en),
        .word_idx_o (word_idx)
    );

    for (genvar p = 0; p < NPIX; p++) begin : g_px
        dps_pixel u_px (
            .clk      (clk),
            .rst      (rst),
            .step_i   (step_bus),
            .level_i  (level_i[p*CODE_W +: CODE_W]),
            .mem_o    (pix_mem[p]),
            .frozen_o (pix_frozen[p])
        );
    end

    dps_readout #(.ROWS(ROWS), .COLS(COLS), .LANES(LANES)) u_rd (
        .clk        (clk),
        .rst        (rst),
        .rd_en_i    (rd_en),
        .word_idx_i (word_idx),
        .pix_mem_i  (pix_mem),
        .data_o     (rd_data_o),
        .valid_o    (rd_valid_o),
        .row_o      (rd_row_o),
        .word_o     (rd_word_o)
    );

endmodule

// File: rtl/dps_adc_array_chk.sv
module dps_adc_array_chk
    import dps_pkg::*;
#(
    parameter int NPIX  = 64,
    parameter int WPR   = 2,
    parameter int ROW_W = 2,
    parameter int WRD_W = 1
) (
    input logic             clk,
    input logic             rst,
    input seq_state_e       state,
    input step_bus_t        step,
    input logic [NPIX-1:0]  frozen,
    input code_t            mem0,
    input logic             rd_valid,
    input logic [ROW_W-1:0] rd_row,
    input logic [WRD_W-1:0] rd_word
);

    int lin_idx;
    assign lin_idx = int'(rd_row) * WPR + int'(rd_word);

    // R2: Gray count moves one bit per step
    a_r2_gray_one_bit: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CONV && $past(state) == ST_CONV)
            |-> $countones(step.gray ^ $past(step.gray)) == 1);

    // R2: sweep ends after the last step
    a_r2_sweep_end: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CONV && step.ramp == CODE_MAX) |=> state == ST_HOLD);

    // R6: running conversion advances one step per cycle, no restart
    a_r6_conv_uninterrupted: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CONV && step.ramp != CODE_MAX)
            |=> (state == ST_CONV && step.ramp == $past(step.ramp) + 1'b1));

    // R4: a frozen pixel stays frozen through the sweep
    a_r4_frozen_sticky: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CONV && $past(state) == ST_CONV)
            |-> (($past(frozen) & ~frozen) == '0));

    // R4: a frozen memory holds its value
    a_r4_mem_hold: assert property (@(posedge clk) disable iff (rst)
        ($past(frozen[0]) && frozen[0]) |-> $stable(mem0));

    // R5: consecutive valid words have consecutive positions
    a_r5_index_step: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && $past(rd_valid)) |-> lin_idx == $past(lin_idx) + 1);

    // R7: valid words only follow the readout state
    a_r7_valid_from_read: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(state) == ST_READ);

endmodule

bind dps_adc_array dps_adc_array_chk #(
    .NPIX  (NPIX),
    .WPR   (WPR),
    .ROW_W (ROW_W),
    .WRD_W (WRD_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .state    (seq_state),
    .step     (step_bus),
    .frozen   (pix_frozen),
    .mem0     (pix_mem[0]),
    .rd_valid (rd_valid_o),
    .rd_row   (rd_row_o),
    .rd_word  (rd_word_o)
);

// File: tb/dps_adc_array_bench.sv
module dps_adc_array_bench;

    localparam int ROWS   = 4;
    localparam int COLS   = 16;
    localparam int LANES  = 8;
    localparam int NPIX   = ROWS * COLS;
    localparam int WPR    = COLS / LANES;
    localparam int NWORDS = ROWS * WPR;
    localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int WRD_W  = (WPR > 1) ? $clog2(WPR) : 1;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic [NPIX*8-1:0]      level_i;
    logic                   start_i = 1'b0;
    logic                   read_i = 1'b0;
    logic [LANES*8-1:0]     rd_data_o;
    logic                   rd_valid_o;
    logic [ROW_W-1:0]       rd_row_o;
    logic [WRD_W-1:0]       rd_word_o;

    logic [7:0] drv   [NPIX];
    logic [7:0] exp_l [NPIX];

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int p = 0; p < NPIX; p++) level_i[p*8 +: 8] = drv[p];
    end

    dps_adc_array #(.ROWS(ROWS), .COLS(COLS), .LANES(LANES)) u_dps_adc_array (
        .clk        (clk),
        .rst        (rst),
        .level_i    (level_i),
        .start_i    (start_i),
        .read_i     (read_i),
        .rd_data_o  (rd_data_o),
        .rd_valid_o (rd_valid_o),
        .rd_row_o   (rd_row_o),
        .rd_word_o  (rd_word_o)
    );

    function automatic logic [LANES*8-1:0] exp_word(int idx);
        logic [LANES*8-1:0] w;
        for (int j = 0; j < LANES; j++) w[j*8 +: 8] = exp_l[idx*LANES + j];
        return w;
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Conversion; optionally pokes start and read mid-sweep (R6, R7)
    task automatic do_conv(bit poke);
        int seen;
        seen = 0;
        @(negedge clk);
        start_i = 1'b1;
        for (int p = 0; p < NPIX; p++) exp_l[p] = drv[p];
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 262; i++) begin
            @(negedge clk);
            if (rd_valid_o) seen++;
            start_i = poke && (i == 100);
            read_i  = poke && (i == 120);
        end
        start_i = 1'b0;
        read_i  = 1'b0;
        check(seen == 0, "R7", "valid during conversion", seen, 0);
    endtask

    // Readout; optionally strobes start during the drain (R6)
    task automatic do_read(string req, bit start_mid);
        int cnt;
        cnt = 0;
        @(negedge clk);
        read_i = 1'b1;
        @(negedge clk);
        read_i = 1'b0;
        for (int i = 0; i < NWORDS + 4; i++) begin
            @(negedge clk);
            if (rd_valid_o) begin
                check(int'(rd_row_o) == cnt / WPR, "R5", "row index", rd_row_o, cnt / WPR);
                check(int'(rd_word_o) == cnt % WPR, "R5", "word index", rd_word_o, cnt % WPR);
                check(rd_data_o == exp_word(cnt), req, "word data", rd_data_o, exp_word(cnt));
                cnt++;
            end
            start_i = start_mid && (i == 1);
        end
        start_i = 1'b0;
        check(cnt == NWORDS, "R5", "word count", cnt, NWORDS);
    endtask

    task automatic expect_quiet(string req, int n);
        int seen;
        seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (rd_valid_o) seen++;
        end
        check(seen == 0, req, "unexpected valid words", seen, 0);
    endtask

    task automatic quiet_read(string req);
        @(negedge clk);
        read_i = 1'b1;
        @(negedge clk);
        read_i = 1'b0;
        expect_quiet(req, NWORDS + 4);
    endtask

    initial begin
        #(100000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int seed;
        seed = 7;
        void'($urandom(seed));
        for (int p = 0; p < NPIX; p++) drv[p] = 8'd0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state and read with no frame
        @(negedge clk);
        check(rd_valid_o == 1'b0, "R1", "valid after reset", rd_valid_o, 0);
        quiet_read("R1");

        // R3: all zero
        do_conv(0);
        do_read("R3", 0);

        // R3: full scale
        for (int p = 0; p < NPIX; p++) drv[p] = 8'd255;
        do_conv(0);
        do_read("R3", 0);

        // R3/R5: distinct pattern per pixel, includes 0 and 255 corners
        for (int p = 0; p < NPIX; p++) drv[p] = 8'((p * 37 + 1) % 256);
        drv[0] = 8'd0;
        drv[NPIX-1] = 8'd255;
        drv[9] = 8'd1;
        drv[10] = 8'd254;
        do_conv(0);
        do_read("R3", 0);

        // R6/R7: random levels, start and read poked mid-conversion
        for (int p = 0; p < NPIX; p++) drv[p] = 8'($urandom);
        do_conv(1);
        do_read("R6", 0);

        // R7: second read after drain gives nothing
        quiet_read("R7");

        // R4/R6: change levels and strobe start while frame waits
        for (int p = 0; p < NPIX; p++) drv[p] = 8'($urandom);
        do_conv(0);
        for (int p = 0; p < NPIX; p++) drv[p] = 8'($urandom);
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (5) @(negedge clk);
        do_read("R4", 0);

        // R6: start during readout does not cut the drain
        for (int p = 0; p < NPIX; p++) drv[p] = 8'($urandom);
        do_conv(0);
        do_read("R6", 1);
        quiet_read("R6");

        // R3: more random frames
        for (int k = 0; k < 3; k++) begin
            for (int p = 0; p < NPIX; p++) drv[p] = 8'($urandom);
            do_conv(0);
            do_read("R3", 0);
        end

        done = 1;
        finish_run();
    end

endmodule